// File: doc/BRIEF.md
# Bulk Command Stream Register Decoder

This block takes a byte stream from a host bulk channel, one byte per valid/ready handshake, and splits it into framed commands. Each command starts with the prefix byte 0xAF and an opcode byte. A register-write command updates a 256-entry, byte-wide video register file. The committed contents of that file drive the block's outputs: colour depth, the two framebuffer base pointers, the raster timing words, the pixel-clock divisor and the blank mode.

Register 0xFF is a lock control. While the file is locked, writes are staged in a shadow copy and the outputs stay frozen. Unlocking copies the whole shadow file to the active file in one clock, so a complete mode change appears on the outputs at once.

A pixel-copy command is also recognised. Its source address, pixel count and destination address are presented on a side port as a valid/ready pulse. The stream input stalls only while that pulse is waiting for a consumer that is not ready.

Top module: `bulk_regdec`

## Requirements
- R1: After reset, every register output and `err_count` are zero, the file is unlocked, `cp_valid` is 0 and `in_ready` is 1.
- R2: The frame 0xAF, 0x20, address, data writes data to that register. While unlocked, the new value is on the outputs in the cycle after the data byte is accepted.
- R3: Writing 0x00 to register 0xFF locks the file. Register writes made after that do not change any output.
- R4: Writing 0xFF to register 0xFF unlocks the file. Every value staged while locked reaches the outputs together, in the cycle after that byte.
- R5: Writing any value other than 0x00 or 0xFF to register 0xFF leaves the lock state unchanged, and staged values stay hidden.
- R6: The timing words are 16-bit, high byte at address N and low byte at N+1, for N = 0x01, 0x03, 0x05, 0x07, 0x09, 0x0B, 0x0D, 0x0F, 0x11, 0x13, 0x15 and 0x17.
- R7: The pixel-clock word takes its low byte from 0x1B and its high byte from 0x1C.
- R8: `depth_sel` is register 0x00 and `blank_mode` is register 0x1F. `base16` is {0x20,0x21,0x22} and `base8` is {0x26,0x27,0x28}, most significant byte first.
- R9: The frame 0xAF, 0x6A followed by seven bytes raises `cp_valid`. The seven bytes are a 3-byte source address (MSB first), a 1-byte count and a 3-byte destination address (MSB first); they appear on `cp_src`, `cp_count` and `cp_dst`.
- R10: `cp_valid` and the copy fields hold until `cp_ready` is high. `in_ready` is low exactly while `cp_valid` is high and `cp_ready` is low.
- R11: Any byte other than 0xAF in prefix position is discarded and increments `err_count`, which saturates at its all-ones value and never decreases.
- R12: After an unknown opcode, bytes are discarded without counting errors until the next 0xAF, which starts a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Stream byte accepted when high with in_valid |
| depth_sel | output | 8 | Colour depth select (register 0x00) |
| base16 | output | 24 | 16 bpp segment base pointer |
| base8 | output | 24 | 8 bpp segment base pointer |
| blank_mode | output | 8 | Blank mode (register 0x1F) |
| h_act_start | output | 16 | Timing word at 0x01 |
| h_act_end | output | 16 | Timing word at 0x03 |
| v_act_start | output | 16 | Timing word at 0x05 |
| v_act_end | output | 16 | Timing word at 0x07 |
| h_last | output | 16 | Timing word at 0x09 |
| hsync_on | output | 16 | Timing word at 0x0B |
| hsync_off | output | 16 | Timing word at 0x0D |
| h_width | output | 16 | Timing word at 0x0F |
| v_last | output | 16 | Timing word at 0x11 |
| vsync_on | output | 16 | Timing word at 0x13 |
| vsync_off | output | 16 | Timing word at 0x15 |
| v_height | output | 16 | Timing word at 0x17 |
| pclk_div | output | 16 | Pixel-clock word, low byte at 0x1B |
| cp_valid | output | 1 | Copy command fields valid |
| cp_ready | input | 1 | Copy consumer ready |
| cp_src | output | 24 | Copy source address |
| cp_count | output | 8 | Copy pixel count |
| cp_dst | output | 24 | Copy destination address |
| err_count | output | ERR_W | Saturating count of bad prefix bytes |

## Verification
The hardest case to reach is the atomic commit. It needs a lock, several staged writes spread over different registers, a write of a non-control value to the lock register, and then the unlock. Only after all of that does every staged value have to appear in the same cycle. The bench builds this sequence from whole command frames, checks after each step that the outputs still show the old values, and then checks all the new values in the cycle after the unlock. Error counter saturation is reached by streaming a long run of stray bytes in prefix position.

// File: rtl/bulk_regdec.sv
module bulk_regdec #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic [7:0]       depth_sel,
  output logic [23:0]      base16,
  output logic [23:0]      base8,
  output logic [7:0]       blank_mode,
  output logic [15:0]      h_act_start,
  output logic [15:0]      h_act_end,
  output logic [15:0]      v_act_start,
  output logic [15:0]      v_act_end,
  output logic [15:0]      h_last,
  output logic [15:0]      hsync_on,
  output logic [15:0]      hsync_off,
  output logic [15:0]      h_width,
  output logic [15:0]      v_last,
  output logic [15:0]      vsync_on,
  output logic [15:0]      vsync_off,
  output logic [15:0]      v_height,
  output logic [15:0]      pclk_div,
  output logic             cp_valid,
  input  logic             cp_ready,
  output logic [23:0]      cp_src,
  output logic [7:0]       cp_count,
  output logic [23:0]      cp_dst,
  output logic [ERR_W-1:0] err_count
);
  localparam logic [7:0] PREFIX = 8'hAF;
  localparam logic [7:0] OP_WR  = 8'h20;
  localparam logic [7:0] OP_CP  = 8'h6A;
  localparam logic [7:0] LOCK_A = 8'hFF;
  localparam int         CP_LEN = 7;
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  typedef enum logic [2:0] {S_PRE, S_OPC, S_ADR, S_DAT, S_CPY, S_SKIP} st_t;

  st_t        st;
  logic [7:0] act [256];
  logic [7:0] shd [256];
  logic [7:0] adr;
  logic [2:0] idx;
  logic [47:0] cbuf;
  logic       locked;
  logic       fire;
  logic [55:0] cfull;

  assign in_ready = !cp_valid || cp_ready;
  assign fire     = in_valid && in_ready;
  assign cfull    = {cbuf, in_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_PRE;
      adr       <= '0;
      idx       <= '0;
      cbuf      <= '0;
      locked    <= 1'b0;
      cp_valid  <= 1'b0;
      cp_src    <= '0;
      cp_count  <= '0;
      cp_dst    <= '0;
      err_count <= '0;
      for (int i = 0; i < 256; i++) begin
        act[i] <= '0;
        shd[i] <= '0;
      end
    end else begin
      if (cp_valid && cp_ready) cp_valid <= 1'b0;
      if (fire) begin
        case (st)
          S_PRE: begin
            if (in_data == PREFIX) st <= S_OPC;
            else if (err_count != ERR_MAX) err_count <= err_count + 1'b1;
          end
          S_OPC: begin
            idx <= '0;
            if (in_data == OP_WR) st <= S_ADR;
            else if (in_data == OP_CP) st <= S_CPY;
            else st <= S_SKIP;
          end
          S_ADR: begin
            adr <= in_data;
            st  <= S_DAT;
          end
          S_DAT: begin
            st <= S_PRE;
            if (adr == LOCK_A) begin
              if (in_data == 8'h00) locked <= 1'b1;
              else if (in_data == 8'hFF) begin
                locked <= 1'b0;
                for (int i = 0; i < 256; i++) act[i] <= shd[i];
              end
            end else begin
              shd[adr] <= in_data;
              if (!locked) act[adr] <= in_data;
            end
          end
          S_CPY: begin
            cbuf <= cfull[47:0];
            if (idx == 3'(CP_LEN - 1)) begin
              cp_valid <= 1'b1;
              cp_src   <= cfull[55:32];
              cp_count <= cfull[31:24];
              cp_dst   <= cfull[23:0];
              st       <= S_PRE;
            end else idx <= idx + 1'b1;
          end
          S_SKIP: if (in_data == PREFIX) st <= S_OPC;
          default: st <= S_PRE;
        endcase
      end
    end
  end

  assign depth_sel   = act[8'h00];
  assign blank_mode  = act[8'h1F];
  assign base16      = {act[8'h20], act[8'h21], act[8'h22]};
  assign base8       = {act[8'h26], act[8'h27], act[8'h28]};
  assign h_act_start = {act[8'h01], act[8'h02]};
  assign h_act_end   = {act[8'h03], act[8'h04]};
  assign v_act_start = {act[8'h05], act[8'h06]};
  assign v_act_end   = {act[8'h07], act[8'h08]};
  assign h_last      = {act[8'h09], act[8'h0A]};
  assign hsync_on    = {act[8'h0B], act[8'h0C]};
  assign hsync_off   = {act[8'h0D], act[8'h0E]};
  assign h_width     = {act[8'h0F], act[8'h10]};
  assign v_last      = {act[8'h11], act[8'h12]};
  assign vsync_on    = {act[8'h13], act[8'h14]};
  assign vsync_off   = {act[8'h15], act[8'h16]};
  assign v_height    = {act[8'h17], act[8'h18]};
  assign pclk_div    = {act[8'h1C], act[8'h1B]};
endmodule

// File: rtl/bulk_regdec_chk.sv
module bulk_regdec_chk #(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             cp_valid,
  input logic             cp_ready,
  input logic [23:0]      cp_src,
  input logic [7:0]       cp_count,
  input logic [23:0]      cp_dst,
  input logic [ERR_W-1:0] err_count,
  input logic             locked,
  input logic [7:0]       blank_mode,
  input logic [23:0]      base16,
  input logic [15:0]      h_width
);
  // R10
  cp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cp_valid && !cp_ready |=> cp_valid && $stable(cp_src) && $stable(cp_count) && $stable(cp_dst));

  // R10
  stall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> cp_valid && !cp_ready);

  // R11
  err_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> err_count >= $past(err_count));

  // R3
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> !locked || ($stable(blank_mode) && $stable(base16) && $stable(h_width)));
endmodule

bind bulk_regdec bulk_regdec_chk #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .cp_valid(cp_valid),
  .cp_ready(cp_ready), .cp_src(cp_src), .cp_count(cp_count), .cp_dst(cp_dst),
  .err_count(err_count), .locked(locked), .blank_mode(blank_mode),
  .base16(base16), .h_width(h_width)
);

// File: tb/bulk_regdec_tb.sv
module bulk_regdec_tb;
  logic clk = 0, rst_n = 0, in_valid = 0, cp_ready = 1;
  logic [7:0] in_data = 0;
  logic in_ready, cp_valid;
  logic [7:0] depth_sel, blank_mode, cp_count, err_count;
  logic [23:0] base16, base8, cp_src, cp_dst;
  logic [15:0] h_act_start, h_act_end, v_act_start, v_act_end, h_last, hsync_on;
  logic [15:0] hsync_off, h_width, v_last, vsync_on, vsync_off, v_height, pclk_div;
  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  bulk_regdec u_dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk);
    in_valid = 1; in_data = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    send(8'hAF); send(8'h20); send(a); send(d);
  endtask

  task automatic t_reset();
    check("R1 blank", blank_mode, 0);
    check("R1 base16", base16, 0);
    check("R1 pclk", pclk_div, 0);
    check("R1 err", err_count, 0);
    check("R1 ready", in_ready, 1);
    check("R1 cp_valid", cp_valid, 0);
  endtask

  task automatic t_write();
    wr(8'h0F, 8'h05);
    check("R2 hi byte", h_width, 16'h0500);
    wr(8'h10, 8'h00);
    wr(8'h17, 8'h04); wr(8'h18, 8'h38);
    check("R6 v_height", v_height, 16'h0438);
    wr(8'h0D, 8'h12); wr(8'h0E, 8'h34);
    check("R6 hsync_off", hsync_off, 16'h1234);
    wr(8'h01, 8'hBE); wr(8'h02, 8'hEF);
    check("R6 h_act_start", h_act_start, 16'hBEEF);
  endtask

  task automatic t_pclk();
    wr(8'h1B, 8'h34); wr(8'h1C, 8'h12);
    check("R7 pclk", pclk_div, 16'h1234);
  endtask

  task automatic t_fields();
    wr(8'h00, 8'h01);
    check("R8 depth", depth_sel, 1);
    wr(8'h20, 8'h11); wr(8'h21, 8'h22); wr(8'h22, 8'h33);
    check("R8 base16", base16, 24'h112233);
    wr(8'h26, 8'h0A); wr(8'h27, 8'h0B); wr(8'h28, 8'h0C);
    check("R8 base8", base8, 24'h0A0B0C);
    wr(8'h1F, 8'h07);
    check("R8 blank", blank_mode, 7);
  endtask

  task automatic t_lock();
    wr(8'hFF, 8'h00);
    wr(8'h0F, 8'h07); wr(8'h10, 8'h80); wr(8'h1F, 8'h01); wr(8'h22, 8'h44);
    check("R3 h_width frozen", h_width, 16'h0500);
    check("R3 blank frozen", blank_mode, 7);
    check("R3 base16 frozen", base16, 24'h112233);
    wr(8'hFF, 8'h55);
    check("R5 still locked", blank_mode, 7);
    wr(8'h1F, 8'h05);
    check("R5 staged hidden", blank_mode, 7);
    wr(8'hFF, 8'hFF);
    check("R4 h_width", h_width, 16'h0780);
    check("R4 blank", blank_mode, 5);
    check("R4 base16", base16, 24'h112244);
    wr(8'h1F, 8'h00);
    check("R4 unlocked direct", blank_mode, 0);
  endtask

  task automatic t_copy();
    send(8'hAF); send(8'h6A);
    send(8'h12); send(8'h34); send(8'h56); send(8'h09);
    send(8'hAB); send(8'hCD);
    cp_ready = 0;
    send(8'hEF);
    check("R9 valid", cp_valid, 1);
    check("R9 src", cp_src, 24'h123456);
    check("R9 count", cp_count, 8'h09);
    check("R9 dst", cp_dst, 24'hABCDEF);
    check("R10 stall", in_ready, 0);
    in_valid = 1; in_data = 8'hAF;
    repeat (3) @(negedge clk);
    check("R10 hold", cp_valid, 1);
    check("R10 hold src", cp_src, 24'h123456);
    check("R10 still stalled", in_ready, 0);
    cp_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check("R10 released", cp_valid, 0);
    check("R10 ready", in_ready, 1);
    send(8'h20); send(8'h1F); send(8'h01);
    check("R10 byte kept", blank_mode, 1);
  endtask

  task automatic t_badpre();
    send(8'h11); send(8'h22);
    check("R11 count", err_count, 2);
    wr(8'h1F, 8'h00);
    check("R11 recover", blank_mode, 0);
  endtask

  task automatic t_unknown();
    send(8'hAF); send(8'h55); send(8'h12); send(8'h34);
    check("R12 no err", err_count, 2);
    wr(8'h1F, 8'h05);
    check("R12 resync", blank_mode, 5);
  endtask

  task automatic t_sat();
    for (int i = 0; i < 260; i++) send(8'h00);
    check("R11 saturate", err_count, 8'hFF);
  endtask

  initial begin
    #2000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write();
    t_pclk();
    t_fields();
    t_lock();
    t_copy();
    t_badpre();
    t_unknown();
    t_sat();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule